// File: doc/BRIEF.md
# Rename History Buffer

This block keeps the per-thread record of register renames for an out-of-order core. Every destination operand that rename maps adds one record to the young end of a circular buffer. A record holds the instruction's sequence number, the architectural register, the physical register just assigned and the physical register the architectural register pointed to before. The map table, the free list and the scoreboard live outside the block. The block talks to them only through its output lanes.

A squash to sequence N undoes mappings from the young end. Each undo restores the map entry to the previous register and returns the new register to the free list. New registers in the miscellaneous range (index at or above the combined integer and float count) are also marked ready. A commit of sequence N retires records from the old end and returns each previous register. Both walks handle at most `WALK` records per cycle and hold a busy flag while more remain.

Push is a valid/ready stream. The producer holds its record until `push_ready` is high in a cycle where `push_valid` is high. Back-pressure appears when the buffer is full, in any cycle that carries a squash, and while a rollback is still walking. The output lanes are plain per-cycle strobes that the map table, free list and scoreboard always accept. In a rollback, lane 0 is the newest record and higher lanes are older. Where two lanes restore the same architectural register in one cycle, the higher lane must win.

Top module: `rename_history`

## Requirements
- R1: After reset the buffer is empty: `push_ready`=1, `full`=0, `rb_busy`=0, `cm_busy`=0, and no lane strobe is high.
- R2: A push is taken in a cycle with `push_valid` and `push_ready` both high. In that same cycle `sb_clr_vld`=1 and `sb_clr_reg` equals `push_new`, which marks the register not-ready. The record joins the young end.
- R3: `push_ready` is low while the buffer holds `DEPTH` records, in any cycle with `squash_valid` high, and while `rb_busy` is high. A push offered then leaves no trace: no scoreboard strobe and no record.
- R4: A squash to N removes records from the young end, lane 0 newest, while their sequence number is greater than N. Each removal gives `map_vld`, `map_arch`=arch, `map_phys`=previous register, `ret_vld`, and `ret_reg`=new register. `rb_busy` is high in the next cycle only if all `WALK` lanes removed a record and records remain.
- R5: A rollback lane whose new register index is at least `INT_REGS+FP_REGS` also raises `rdy_vld`, with `rdy_reg` equal to that register. No other lane raises `rdy_vld`.
- R6: A squash that finds the buffer empty produces no lane strobe and leaves `rb_busy` low.
- R7: A commit of N removes records from the old end, lane 0 oldest, while their sequence number is at most N. Each removal gives `ret_vld` with `ret_reg`=previous register and no map or ready strobe. `cm_busy` follows the same continuation rule as `rb_busy`.
- R8: A commit whose N is below the oldest record's sequence number removes nothing. The buffer is left unchanged.
- R9: A commit request is dropped when `commit_seq` is 0, when `squash_valid` is high in the same cycle, while `rb_busy` is high, or while `recovering` is high.
- R10: A squash cancels a commit walk in progress: `cm_busy` is low after the rollback, and the records not yet committed stay in the buffer.
- R11: `full` is high exactly when the buffer holds `DEPTH` records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | A rename record is offered |
| push_ready | output | 1 | The offered record is taken this cycle |
| push_seq | input | 16 | Sequence number of the renaming instruction |
| push_arch | input | 5 | Architectural destination register |
| push_new | input | 7 | Physical register just assigned |
| push_prev | input | 7 | Physical register previously mapped |
| sb_clr_vld | output | 1 | Mark `sb_clr_reg` not-ready |
| sb_clr_reg | output | 7 | Register to mark not-ready |
| squash_valid | input | 1 | Squash request this cycle |
| squash_seq | input | 16 | Youngest surviving sequence number |
| commit_valid | input | 1 | Commit request this cycle |
| commit_seq | input | 16 | Youngest committed sequence number |
| recovering | input | 1 | Stage is recovering; commits are dropped |
| map_vld | output | WALK | Per-lane map restore strobe |
| map_arch | output | WALK*5 | Per-lane architectural register to restore |
| map_phys | output | WALK*7 | Per-lane register written back into the map |
| ret_vld | output | WALK | Per-lane free-list return strobe |
| ret_reg | output | WALK*7 | Per-lane register returned to the free list |
| rdy_vld | output | WALK | Per-lane scoreboard set-ready strobe |
| rdy_reg | output | WALK*7 | Per-lane register marked ready |
| full | output | 1 | Buffer holds DEPTH records |
| rb_busy | output | 1 | Rollback walk continues next cycle |
| cm_busy | output | 1 | Commit walk continues next cycle |

## Verification
The bench goes after walks that need several cycles. A design that stopped early would leave records that show up later as unexpected returns. A design that ran past the bound would free registers still in use. It also drives a stale commit, a squash into an empty buffer and a commit in the same cycle as a squash, where a wrong priority or missing guard would return registers that must stay allocated. It cancels a commit walk with a squash; a design that kept walking would leave `cm_busy` high after the rollback. It fills the buffer and offers one more push; if that push were taken, the scoreboard would see a strobe and an extra record would come back at the final drain. A miscellaneous-range register is rolled back to catch a missing or misplaced ready strobe.

// File: rtl/rh_pkg.sv
package rh_pkg;
  localparam int SEQ_W  = 16;
  localparam int ARCH_W = 5;
  localparam int PHYS_W = 7;

  typedef struct packed {
    logic [SEQ_W-1:0]  seq;
    logic [ARCH_W-1:0] arch;
    logic [PHYS_W-1:0] new_p;
    logic [PHYS_W-1:0] prev_p;
  } rec_t;
endpackage

// File: rtl/rh_ring.sv
module rh_ring
  import rh_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WALK  = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  rec_t                 wr_rec,
  input  logic [CW-1:0]        pop_new,
  input  logic [CW-1:0]        pop_old,
  output logic [CW-1:0]        count,
  output rec_t [WALK-1:0]      newest,
  output rec_t [WALK-1:0]      oldest
);
  rec_t          mem [DEPTH];
  logic [AW-1:0] head, tail;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (wr_en) mem[tail] <= wr_rec;
      tail <= tail + AW'(wr_en) - pop_new[AW-1:0];
      head <= head + pop_old[AW-1:0];
      cnt  <= cnt + CW'(wr_en) - pop_new - pop_old;
    end
  end

  generate
    for (genvar i = 0; i < WALK; i++) begin : g_rd
      assign newest[i] = mem[tail - AW'(i + 1)];
      assign oldest[i] = mem[head + AW'(i)];
    end
  endgenerate

  assign count = cnt;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cnt < CW'(DEPTH));
  // R3
  push_vs_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> pop_new == '0);
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_new + pop_old) <= cnt);
endmodule

// File: rtl/rh_scan.sv
module rh_scan
  import rh_pkg::*;
#(
  parameter int WALK = 2,
  parameter int CW   = 5
) (
  input  logic              en,
  input  logic              newer,
  input  logic [SEQ_W-1:0]  bound,
  input  logic [CW-1:0]     avail,
  input  rec_t [WALK-1:0]   recs,
  output logic [WALK-1:0]   take,
  output logic [CW-1:0]     take_n
);
  logic [WALK-1:0] hit;
  logic            run;

  generate
    for (genvar i = 0; i < WALK; i++) begin : g_hit
      assign hit[i] = (CW'(i) < avail) &&
                      (newer ? (recs[i].seq > bound) : (recs[i].seq <= bound));
    end
  endgenerate

  always_comb begin
    run    = en;
    take_n = '0;
    for (int i = 0; i < WALK; i++) begin
      run     = run & hit[i];
      take[i] = run;
      take_n  = take_n + CW'(run);
    end
  end
endmodule

// File: rtl/rename_history.sv
module rename_history
  import rh_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int WALK     = 2,
  parameter int INT_REGS = 48,
  parameter int FP_REGS  = 48
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_valid,
  output logic                   push_ready,
  input  logic [SEQ_W-1:0]       push_seq,
  input  logic [ARCH_W-1:0]      push_arch,
  input  logic [PHYS_W-1:0]      push_new,
  input  logic [PHYS_W-1:0]      push_prev,
  output logic                   sb_clr_vld,
  output logic [PHYS_W-1:0]      sb_clr_reg,
  input  logic                   squash_valid,
  input  logic [SEQ_W-1:0]       squash_seq,
  input  logic                   commit_valid,
  input  logic [SEQ_W-1:0]       commit_seq,
  input  logic                   recovering,
  output logic [WALK-1:0]        map_vld,
  output logic [WALK*ARCH_W-1:0] map_arch,
  output logic [WALK*PHYS_W-1:0] map_phys,
  output logic [WALK-1:0]        ret_vld,
  output logic [WALK*PHYS_W-1:0] ret_reg,
  output logic [WALK-1:0]        rdy_vld,
  output logic [WALK*PHYS_W-1:0] rdy_reg,
  output logic                   full,
  output logic                   rb_busy,
  output logic                   cm_busy
);
  localparam int AW        = $clog2(DEPTH);
  localparam int CW        = AW + 1;
  localparam int MISC_BASE = INT_REGS + FP_REGS;

  logic             rb_q, cm_q, rb_d, cm_d;
  logic [SEQ_W-1:0] rb_tgt, cm_tgt, rb_bound, cm_bound;
  logic             rb_go, cm_start, cm_go, push_fire;
  logic [CW-1:0]    count, rb_n, cm_n;
  logic [WALK-1:0]  rb_take, cm_take;
  rec_t [WALK-1:0]  newest, oldest;
  rec_t             wr_rec;

  assign rb_go    = squash_valid | rb_q;
  assign rb_bound = squash_valid ? squash_seq : rb_tgt;
  assign cm_start = commit_valid && (commit_seq != '0) && !rb_go && !recovering;
  assign cm_go    = (cm_start | cm_q) && !rb_go && !recovering;
  assign cm_bound = cm_start ? commit_seq : cm_tgt;

  assign full       = (count == CW'(DEPTH));
  assign push_ready = !full && !rb_go;
  assign push_fire  = push_valid && push_ready;
  assign sb_clr_vld = push_fire;
  assign sb_clr_reg = push_new;
  assign wr_rec     = '{seq: push_seq, arch: push_arch, new_p: push_new, prev_p: push_prev};

  rh_ring #(.DEPTH(DEPTH), .WALK(WALK)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_en(push_fire), .wr_rec(wr_rec),
    .pop_new(rb_n), .pop_old(cm_n), .count(count),
    .newest(newest), .oldest(oldest)
  );

  rh_scan #(.WALK(WALK), .CW(CW)) u_roll (
    .en(rb_go), .newer(1'b1), .bound(rb_bound), .avail(count),
    .recs(newest), .take(rb_take), .take_n(rb_n)
  );

  rh_scan #(.WALK(WALK), .CW(CW)) u_retire (
    .en(cm_go), .newer(1'b0), .bound(cm_bound), .avail(count),
    .recs(oldest), .take(cm_take), .take_n(cm_n)
  );

  assign rb_d = rb_go && (rb_n == CW'(WALK)) && (count != CW'(WALK));
  assign cm_d = cm_go && (cm_n == CW'(WALK)) && (count != CW'(WALK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_q   <= 1'b0;
      cm_q   <= 1'b0;
      rb_tgt <= '0;
      cm_tgt <= '0;
    end else begin
      rb_q   <= rb_d;
      cm_q   <= cm_d;
      rb_tgt <= rb_bound;
      cm_tgt <= cm_bound;
    end
  end

  assign rb_busy = rb_q;
  assign cm_busy = cm_q;

  generate
    for (genvar i = 0; i < WALK; i++) begin : g_lane
      assign map_vld[i]                  = rb_take[i];
      assign map_arch[i*ARCH_W +: ARCH_W] = newest[i].arch;
      assign map_phys[i*PHYS_W +: PHYS_W] = newest[i].prev_p;
      assign ret_vld[i]                  = rb_take[i] | cm_take[i];
      assign ret_reg[i*PHYS_W +: PHYS_W]  = rb_take[i] ? newest[i].new_p : oldest[i].prev_p;
      assign rdy_vld[i]                  = rb_take[i] && (int'(newest[i].new_p) >= MISC_BASE);
      assign rdy_reg[i*PHYS_W +: PHYS_W]  = newest[i].new_p;
    end
  endgenerate

  // R6
  empty_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_valid && count == '0) |=> !rb_busy);
  // R4
  roll_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_busy) |-> $past(map_vld) == {WALK{1'b1}});
  // R7
  commit_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cm_busy) |-> ($past(ret_vld) == {WALK{1'b1}} && $past(map_vld) == '0));
endmodule

// File: tb/rename_history_test.sv
`timescale 1ns/100ps
module rename_history_test;
  localparam int DEPTH = 16;
  localparam int WALK  = 2;
  localparam int MISC  = 96;

  typedef struct packed {
    logic [15:0] seq;
    logic [4:0]  arch;
    logic [6:0]  np;
    logic [6:0]  pp;
  } mrec_t;

  typedef struct packed {
    logic       roll;
    logic [4:0] arch;
    logic [6:0] ret;
    logic [6:0] mapp;
    logic       rdy;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_ready;
  logic [15:0] push_seq = 0;
  logic [4:0]  push_arch = 0;
  logic [6:0]  push_new = 0, push_prev = 0;
  logic sb_clr_vld;
  logic [6:0] sb_clr_reg;
  logic squash_valid = 0;
  logic [15:0] squash_seq = 0;
  logic commit_valid = 0;
  logic [15:0] commit_seq = 0;
  logic recovering = 0;
  logic [WALK-1:0] map_vld, ret_vld, rdy_vld;
  logic [WALK*5-1:0] map_arch;
  logic [WALK*7-1:0] map_phys, ret_reg, rdy_reg;
  logic full, rb_busy, cm_busy;

  int n_chk = 0, n_fail = 0;
  int seq_ctr = 0;
  bit mon_on = 0;
  bit done = 0;
  mrec_t m_q[$];
  exp_t  e_q[$];
  string t_q[$];

  always #2 clk = ~clk;

  rename_history uut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ready(push_ready), .push_seq(push_seq),
    .push_arch(push_arch), .push_new(push_new), .push_prev(push_prev),
    .sb_clr_vld(sb_clr_vld), .sb_clr_reg(sb_clr_reg),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .commit_valid(commit_valid), .commit_seq(commit_seq), .recovering(recovering),
    .map_vld(map_vld), .map_arch(map_arch), .map_phys(map_phys),
    .ret_vld(ret_vld), .ret_reg(ret_reg), .rdy_vld(rdy_vld), .rdy_reg(rdy_reg),
    .full(full), .rb_busy(rb_busy), .cm_busy(cm_busy)
  );

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk); #0.5;
  endtask

  // monitor: compare every lane strobe against the expected queue
  always @(negedge clk) begin
    if (mon_on) begin
      for (int i = 0; i < WALK; i++) begin
        if (ret_vld[i] || map_vld[i]) begin
          if (e_q.size() == 0) begin
            check(0, "R8", "unexpected lane return reg", int'(ret_reg[i*7 +: 7]), -1);
          end else begin
            exp_t e;
            string t;
            e = e_q.pop_front();
            t = t_q.pop_front();
            check(map_vld[i] == e.roll, t, "map strobe", int'(map_vld[i]), int'(e.roll));
            check(ret_vld[i] == 1'b1, t, "ret strobe", int'(ret_vld[i]), 1);
            check(ret_reg[i*7 +: 7] == e.ret, t, "ret reg", int'(ret_reg[i*7 +: 7]), int'(e.ret));
            check(rdy_vld[i] == e.rdy, "R5", "ready strobe", int'(rdy_vld[i]), int'(e.rdy));
            if (e.roll) begin
              check(map_arch[i*5 +: 5] == e.arch, t, "map arch", int'(map_arch[i*5 +: 5]), int'(e.arch));
              check(map_phys[i*7 +: 7] == e.mapp, t, "map phys", int'(map_phys[i*7 +: 7]), int'(e.mapp));
            end
            if (e.rdy)
              check(rdy_reg[i*7 +: 7] == e.ret, "R5", "ready reg", int'(rdy_reg[i*7 +: 7]), int'(e.ret));
          end
        end
      end
    end
  end

  task automatic push_one(input logic [4:0] arch, input logic [6:0] np, input logic [6:0] pp);
    bit exp_rdy;
    exp_rdy = (m_q.size() < DEPTH);
    push_valid = 1; push_seq = 16'(seq_ctr + 1);
    push_arch = arch; push_new = np; push_prev = pp;
    @(negedge clk);
    check(push_ready == exp_rdy, "R3", "push_ready", int'(push_ready), int'(exp_rdy));
    check(sb_clr_vld == exp_rdy, "R2", "scoreboard clear strobe", int'(sb_clr_vld), int'(exp_rdy));
    if (exp_rdy)
      check(sb_clr_reg == np, "R2", "scoreboard clear reg", int'(sb_clr_reg), int'(np));
    tick();
    push_valid = 0;
    if (exp_rdy) begin
      seq_ctr++;
      m_q.push_back('{seq: 16'(seq_ctr), arch: arch, np: np, pp: pp});
    end
  endtask

  task automatic expect_roll(input logic [15:0] n);
    while (m_q.size() > 0 && m_q[$].seq > n) begin
      mrec_t r;
      r = m_q.pop_back();
      e_q.push_back('{roll: 1'b1, arch: r.arch, ret: r.np, mapp: r.pp, rdy: (int'(r.np) >= MISC)});
      t_q.push_back("R4");
    end
  endtask

  task automatic expect_commit_one();
    mrec_t r;
    r = m_q.pop_front();
    e_q.push_back('{roll: 1'b0, arch: r.arch, ret: r.pp, mapp: 7'd0, rdy: 1'b0});
    t_q.push_back("R7");
  endtask

  task automatic wait_idle(string req);
    int g;
    g = 0;
    @(negedge clk);
    while ((rb_busy || cm_busy) && g < 50) begin
      if (rb_busy)
        check(push_ready == 0, "R3", "push_ready during rollback", int'(push_ready), 0);
      @(negedge clk);
      g++;
    end
    check(!rb_busy && !cm_busy, req, "walk finished", int'({rb_busy, cm_busy}), 0);
    @(posedge clk); #0.5;
  endtask

  task automatic do_squash(input logic [15:0] n, input bit with_commit);
    expect_roll(n);
    squash_valid = 1; squash_seq = n;
    if (with_commit) begin commit_valid = 1; commit_seq = 16'hFFFF; end
    @(negedge clk);
    check(push_ready == 0, "R3", "push_ready in squash cycle", int'(push_ready), 0);
    tick();
    squash_valid = 0; commit_valid = 0;
    wait_idle("R4");
    check(e_q.size() == 0, with_commit ? "R9" : "R4", "pending rollbacks", e_q.size(), 0);
  endtask

  task automatic do_commit(input logic [15:0] n, input bit rec, input bit apply, string req);
    if (apply && n != 0)
      while (m_q.size() > 0 && m_q[0].seq <= n) expect_commit_one();
    commit_valid = 1; commit_seq = n; recovering = rec;
    tick();
    commit_valid = 0; recovering = 0;
    wait_idle(req);
    check(e_q.size() == 0, req, "pending commits", e_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(push_ready == 1, "R1", "push_ready", int'(push_ready), 1);
    check(full == 0, "R1", "full", int'(full), 0);
    check(!rb_busy && !cm_busy, "R1", "busy", int'({rb_busy, cm_busy}), 0);
    check(ret_vld == 0 && map_vld == 0 && rdy_vld == 0, "R1", "lanes idle", int'(ret_vld), 0);
    @(posedge clk); #0.5;
    mon_on = 1;

    // R2 pushes, one in miscellaneous range
    push_one(5'd1, 7'd10, 7'd1);
    push_one(5'd2, 7'd11, 7'd2);
    push_one(5'd3, 7'd12, 7'd3);
    push_one(5'd4, 7'd13, 7'd4);
    push_one(5'd5, 7'd100, 7'd5);
    push_one(5'd6, 7'd15, 7'd6);
    // R4 R5 multi-cycle rollback
    do_squash(16'd3, 0);
    // R7 commit of two
    do_commit(16'd2, 0, 1, "R7");
    // R8 stale commit: oldest is seq 3
    do_commit(16'd2, 0, 1, "R8");
    push_one(5'd7, 7'd20, 7'd30);
    push_one(5'd8, 7'd21, 7'd31);
    push_one(5'd9, 7'd22, 7'd32);
    push_one(5'd10, 7'd23, 7'd33);
    // R9 zero sequence and recovering drop the commit
    do_commit(16'd0, 0, 0, "R9");
    do_commit(16'd100, 1, 0, "R9");
    // R7 multi-cycle commit, seq 3,7,8
    do_commit(16'd8, 0, 1, "R7");
    do_commit(16'd100, 0, 1, "R7");
    // R6 squash on empty buffer
    do_squash(16'd0, 0);
    @(negedge clk);
    check(push_ready == 1, "R6", "push_ready after empty squash", int'(push_ready), 1);
    @(posedge clk); #0.5;

    // R11 fill to depth
    s0 = seq_ctr + 1;
    for (int i = 0; i < DEPTH; i++)
      push_one(5'(i), 7'(40 + i), 7'(70 + i));
    @(negedge clk);
    check(full == 1, "R11", "full at depth", int'(full), 1);
    @(posedge clk); #0.5;
    // R3 push while full is not taken
    push_one(5'd31, 7'd90, 7'd91);
    // R9 squash and commit same cycle: rollback only
    do_squash(16'(s0 + 13), 1);
    @(negedge clk);
    check(full == 0, "R11", "not full after rollback", int'(full), 0);
    @(posedge clk); #0.5;

    // R10 squash cancels commit walk
    expect_commit_one();
    expect_commit_one();
    commit_valid = 1; commit_seq = 16'(s0 + 5);
    tick();
    commit_valid = 0;
    expect_roll(16'(s0 + 9));
    squash_valid = 1; squash_seq = 16'(s0 + 9);
    @(negedge clk);
    check(cm_busy == 1, "R7", "commit walk pending", int'(cm_busy), 1);
    tick();
    squash_valid = 0;
    wait_idle("R10");
    check(cm_busy == 0, "R10", "commit walk cancelled", int'(cm_busy), 0);
    // remaining s0+2..s0+9 drain
    do_commit(16'hFFFF, 0, 1, "R10");
    @(negedge clk);
    check(ret_vld == 0, "R8", "no stray returns", int'(ret_vld), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule